// File: doc/BRIEF.md
# Interrupt State Register Bank

This block keeps the per-source interrupt state that a priority arbiter and a processor core consult: an enable flag, a pending flag and an active flag for each of 60 sources, and a 4-bit priority level for each source. Software reaches the state over a word-wide request/response bus. Hardware raises pending flags from source request pulses. It moves a source from pending to active when its handler starts, and drops the active flag when the handler returns. The flags are packed into 32-bit words. Source n sits in word n/32 at bit n%32. The full flag vectors and all priority levels also leave the block as plain status pins, so that an arbiter can read them without using the bus.

Enable and pending flags are changed only through paired addresses. One word of the pair sets, and the other clears, every flag whose data bit is 1. A data bit of 0 leaves its flag alone. The active flags cannot be written from the bus. Each priority byte keeps only its upper nibble.

The bus uses valid/ready on both sides. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. A read returns its word on the next cycle with `rsp_valid` high. That word stays on the bus until `rsp_ready` is seen high. While a response is held back this way, `req_ready` is low and no new request is taken. Writes produce no response.

Top module: `irq_state_bank`

## Requirements
- R1: After reset every enable, pending and active flag and every priority level is zero, and `rsp_valid` is low.
- R2: Writing the set-enable words (0x000 for sources 0-31, 0x004 for sources 32-59) turns on each enable flag whose data bit is 1, and data bits of 0 change nothing. A read of a set-enable word or a clear-enable word returns the current enable flags.
- R3: Writing the clear-enable words (0x080, 0x084) turns off each enable flag whose data bit is 1, and data bits of 0 change nothing.
- R4: The set-pending words (0x100, 0x104) and the clear-pending words (0x180, 0x184) set and clear pending flags under the same one-bits-only rule, and reads return the pending flags.
- R5: A one-cycle pulse on `src_req[n]` sets pending flag n. If a clear-pending write for bit n is taken in the same cycle, the flag still ends up set.
- R6: `entry_valid` with id n clears pending flag n and sets active flag n. `exit_valid` with id n clears active flag n. Active flags read at 0x200 and 0x204.
- R7: Writes to the active words leave every active flag unchanged.
- R8: Bits 31:28 of every word at offset 0x004 read as zero, and writing 1 to them changes no state.
- R9: Byte 0x300+n holds the priority of source n in bits 7:4, and bits 3:0 read as zero. A byte lane whose `req_be` bit is low is not written, and the same lane rule applies to every writable word.
- R10: A read taken at one clock edge gives `rsp_valid` and its data after that edge. Data and `rsp_valid` hold while `rsp_ready` is low, and `req_ready` stays low during that time.
- R11: Addresses outside the mapped words, including 0x33C and above, read as zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus request present |
| req_ready | output | 1 | Bus request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address, word aligned |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte lane write strobes |
| rsp_valid | output | 1 | Read data present |
| rsp_ready | input | 1 | Read data taken |
| rsp_rdata | output | 32 | Read data |
| src_req | input | 60 | Per-source request pulses |
| entry_valid | input | 1 | Handler entry event |
| entry_id | input | 6 | Source entering its handler |
| exit_valid | input | 1 | Handler exit event |
| exit_id | input | 6 | Source leaving its handler |
| enable_o | output | 60 | Enable flags |
| pending_o | output | 60 | Pending flags |
| active_o | output | 60 | Active flags |
| prio_o | output | 240 | Priority levels, 4 bits per source |

## Verification
The following are checked on every cycle:
- A flag changes only where a set or a clear was aimed at it.
- A hardware request always leaves its pending flag set, even when a clear arrives in the same cycle.
- A handler exit drops the active flag.
- Bus writes never change the active flags.
- Priority levels stay still when no write is taken.
- A held-back response stays stable.

Some behaviour can only be shown by the bench's scenarios against its own model of the register map:
- The address decode.
- The bit packing across the two words.
- The reserved bits that read as zero.
- The byte-lane masking of priority writes.
- The stall of a second request behind a blocked response.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned DATA_W = 32;

  localparam logic [ADDR_W-1:0] EN_SET_BASE = 12'h000;
  localparam logic [ADDR_W-1:0] EN_CLR_BASE = 12'h080;
  localparam logic [ADDR_W-1:0] PD_SET_BASE = 12'h100;
  localparam logic [ADDR_W-1:0] PD_CLR_BASE = 12'h180;
  localparam logic [ADDR_W-1:0] ACT_BASE    = 12'h200;
  localparam logic [ADDR_W-1:0] PRIO_BASE   = 12'h300;

  typedef enum logic [2:0] {
    KIND_NONE,
    KIND_EN_SET,
    KIND_EN_CLR,
    KIND_PD_SET,
    KIND_PD_CLR,
    KIND_ACT,
    KIND_PRIO
  } reg_kind_e;

  // True when addr lies inside a window of nwords 32-bit words from base.
  function automatic logic in_window(logic [ADDR_W-1:0] addr,
                                     logic [ADDR_W-1:0] base,
                                     int unsigned nwords);
    logic [ADDR_W:0] lo;
    logic [ADDR_W:0] hi;
    lo = {1'b0, base};
    hi = lo + (ADDR_W+1)'(nwords * 4);
    return ({1'b0, addr} >= lo) && ({1'b0, addr} < hi);
  endfunction
endpackage

// File: rtl/irq_bus_port.sv
module irq_bus_port
  import irq_bank_pkg::*;
#(
  parameter int unsigned NWORD  = 2,
  parameter int unsigned NPWORD = 15,
  parameter int unsigned IW     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [3:0]        req_be,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              acc_wr,
  output reg_kind_e         kind,
  output logic [IW-1:0]     idx,
  output logic [DATA_W-1:0] wdata_m,
  output logic [3:0]        be,
  input  logic [DATA_W-1:0] rd_word
);
  logic              accept;
  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] off;

  // Window decode: which register group, and word index inside it.
  always_comb begin
    kind = KIND_NONE;
    base = '0;
    if (in_window(req_addr, EN_SET_BASE, NWORD)) begin
      kind = KIND_EN_SET; base = EN_SET_BASE;
    end else if (in_window(req_addr, EN_CLR_BASE, NWORD)) begin
      kind = KIND_EN_CLR; base = EN_CLR_BASE;
    end else if (in_window(req_addr, PD_SET_BASE, NWORD)) begin
      kind = KIND_PD_SET; base = PD_SET_BASE;
    end else if (in_window(req_addr, PD_CLR_BASE, NWORD)) begin
      kind = KIND_PD_CLR; base = PD_CLR_BASE;
    end else if (in_window(req_addr, ACT_BASE, NWORD)) begin
      kind = KIND_ACT; base = ACT_BASE;
    end else if (in_window(req_addr, PRIO_BASE, NPWORD)) begin
      kind = KIND_PRIO; base = PRIO_BASE;
    end
  end

  assign off = req_addr - base;
  assign idx = off[IW+1:2];
  assign be  = req_be;

  for (genvar l = 0; l < 4; l++) begin : g_lane
    assign wdata_m[l*8 +: 8] = req_be[l] ? req_wdata[l*8 +: 8] : 8'h00;
  end

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign acc_wr    = accept && req_write;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (accept && !req_write) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rd_word;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R10: a response that is not taken stays on the bus unchanged.
  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));
endmodule

// File: rtl/irq_flag_vec.sv
module irq_flag_vec #(
  parameter int unsigned N     = 60,
  parameter int unsigned NWORD = 2,
  parameter int unsigned IW    = 4,
  parameter int unsigned DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sw_set_en,
  input  logic          sw_clr_en,
  input  logic [IW-1:0] sw_idx,
  input  logic [DW-1:0] sw_data,
  input  logic [N-1:0]  hw_set,
  input  logic [N-1:0]  hw_clr,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_word,
  output logic [N-1:0]  q
);
  logic [N-1:0]        set_v;
  logic [N-1:0]        clr_v;
  logic [NWORD*DW-1:0] padded;

  for (genvar i = 0; i < N; i++) begin : g_bit
    localparam int unsigned WRD = i / DW;
    localparam int unsigned BIT = i % DW;
    assign set_v[i] = sw_set_en && (sw_idx == IW'(WRD)) && sw_data[BIT];
    assign clr_v[i] = sw_clr_en && (sw_idx == IW'(WRD)) && sw_data[BIT];
  end

  // Set terms after clear terms: a hardware set beats any clear.
  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= (q & ~(clr_v | hw_clr)) | set_v | hw_set;
  end

  always_comb begin
    padded = '0;
    padded[N-1:0] = q;
    rd_word = '0;
    for (int w = 0; w < NWORD; w++) begin
      if (rd_idx == IW'(w)) rd_word = padded[w*DW +: DW];
    end
  end

  // R5: a hardware set always lands.
  p_hw_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_set != '0) |=> ((q & $past(hw_set)) == $past(hw_set)));

  // R2: bits not addressed by any set or clear keep their value.
  p_quiet_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((q ^ $past(q)) & ~$past(set_v | clr_v | hw_set | hw_clr)) == '0));

  // R6: a hardware clear with no competing set drops the flag.
  p_hw_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((hw_clr & ~hw_set & ~set_v) != '0) |=>
      ((q & $past(hw_clr & ~hw_set & ~set_v)) == '0));
endmodule

// File: rtl/irq_prio_array.sv
module irq_prio_array #(
  parameter int unsigned N      = 60,
  parameter int unsigned PW     = 4,
  parameter int unsigned NPWORD = 15,
  parameter int unsigned IW     = 4,
  parameter int unsigned DW     = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [3:0]    wr_be,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_word,
  output logic [N*PW-1:0] prio_o
);
  logic [NPWORD*DW-1:0] padded;
  logic                 unused_low;

  for (genvar i = 0; i < N; i++) begin : g_src
    localparam int unsigned WRD  = i / 4;
    localparam int unsigned LANE = i % 4;
    logic [PW-1:0] lvl;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lvl <= '0;
      end else if (wr_en && (wr_idx == IW'(WRD)) && wr_be[LANE]) begin
        lvl <= wr_data[LANE*8+7 -: PW];
      end
    end
    assign prio_o[i*PW +: PW] = lvl;
  end

  assign unused_low = ^wr_data;

  // Each level sits in the top of its byte; lower bits stay zero.
  always_comb begin
    padded = '0;
    for (int i = 0; i < N; i++) begin
      padded[i*8+8-PW +: PW] = prio_o[i*PW +: PW];
    end
    rd_word = '0;
    for (int w = 0; w < NPWORD; w++) begin
      if (rd_idx == IW'(w)) rd_word = padded[w*DW +: DW];
    end
  end

  // R9: levels move only on a taken priority write.
  p_prio_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(prio_o));
endmodule

// File: rtl/irq_state_bank.sv
module irq_state_bank
  import irq_bank_pkg::*;
#(
  parameter int unsigned NSRC   = 60,
  parameter int unsigned PRIO_W = 4,
  localparam int unsigned ID_W  = $clog2(NSRC)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [DATA_W-1:0]      req_wdata,
  input  logic [3:0]             req_be,
  output logic                   rsp_valid,
  input  logic                   rsp_ready,
  output logic [DATA_W-1:0]      rsp_rdata,
  input  logic [NSRC-1:0]        src_req,
  input  logic                   entry_valid,
  input  logic [ID_W-1:0]        entry_id,
  input  logic                   exit_valid,
  input  logic [ID_W-1:0]        exit_id,
  output logic [NSRC-1:0]        enable_o,
  output logic [NSRC-1:0]        pending_o,
  output logic [NSRC-1:0]        active_o,
  output logic [NSRC*PRIO_W-1:0] prio_o
);
  localparam int unsigned NWORD  = (NSRC + DATA_W - 1) / DATA_W;
  localparam int unsigned NPWORD = (NSRC + 3) / 4;
  localparam int unsigned IW     = $clog2(NPWORD + 1);

  logic              acc_wr;
  reg_kind_e         kind;
  logic [IW-1:0]     idx;
  logic [DATA_W-1:0] wdata_m;
  logic [3:0]        be;
  logic [DATA_W-1:0] rd_word, en_rd, pd_rd, act_rd, prio_rd;
  logic [NSRC-1:0]   entry_vec, exit_vec;

  for (genvar i = 0; i < NSRC; i++) begin : g_evt
    assign entry_vec[i] = entry_valid && (entry_id == ID_W'(i));
    assign exit_vec[i]  = exit_valid  && (exit_id  == ID_W'(i));
  end

  irq_bus_port #(.NWORD(NWORD), .NPWORD(NPWORD), .IW(IW)) u_port (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .acc_wr(acc_wr), .kind(kind), .idx(idx), .wdata_m(wdata_m), .be(be),
    .rd_word(rd_word)
  );

  irq_flag_vec #(.N(NSRC), .NWORD(NWORD), .IW(IW), .DW(DATA_W)) u_enable (
    .clk(clk), .rst_n(rst_n),
    .sw_set_en(acc_wr && kind == KIND_EN_SET),
    .sw_clr_en(acc_wr && kind == KIND_EN_CLR),
    .sw_idx(idx), .sw_data(wdata_m),
    .hw_set('0), .hw_clr('0),
    .rd_idx(idx), .rd_word(en_rd), .q(enable_o)
  );

  irq_flag_vec #(.N(NSRC), .NWORD(NWORD), .IW(IW), .DW(DATA_W)) u_pending (
    .clk(clk), .rst_n(rst_n),
    .sw_set_en(acc_wr && kind == KIND_PD_SET),
    .sw_clr_en(acc_wr && kind == KIND_PD_CLR),
    .sw_idx(idx), .sw_data(wdata_m),
    .hw_set(src_req), .hw_clr(entry_vec),
    .rd_idx(idx), .rd_word(pd_rd), .q(pending_o)
  );

  irq_flag_vec #(.N(NSRC), .NWORD(NWORD), .IW(IW), .DW(DATA_W)) u_active (
    .clk(clk), .rst_n(rst_n),
    .sw_set_en(1'b0), .sw_clr_en(1'b0),
    .sw_idx(idx), .sw_data(wdata_m),
    .hw_set(entry_vec), .hw_clr(exit_vec),
    .rd_idx(idx), .rd_word(act_rd), .q(active_o)
  );

  irq_prio_array #(.N(NSRC), .PW(PRIO_W), .NPWORD(NPWORD), .IW(IW), .DW(DATA_W)) u_prio (
    .clk(clk), .rst_n(rst_n),
    .wr_en(acc_wr && kind == KIND_PRIO), .wr_idx(idx), .wr_data(wdata_m),
    .wr_be(be), .rd_idx(idx), .rd_word(prio_rd), .prio_o(prio_o)
  );

  always_comb begin
    unique case (kind)
      KIND_EN_SET, KIND_EN_CLR: rd_word = en_rd;
      KIND_PD_SET, KIND_PD_CLR: rd_word = pd_rd;
      KIND_ACT:                 rd_word = act_rd;
      KIND_PRIO:                rd_word = prio_rd;
      default:                  rd_word = '0;
    endcase
  end

  // R7: a bus write to the active words alone never moves an active flag.
  p_act_ro_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && kind == KIND_ACT && !entry_valid && !exit_valid) |=> $stable(active_o));
endmodule

// File: tb/sim_irq_state_bank.sv
`timescale 1ns/1ps
module sim_irq_state_bank;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [11:0]  req_addr = '0;
  logic [31:0]  req_wdata = '0;
  logic [3:0]   req_be = 4'hF;
  logic         req_ready, rsp_valid;
  logic [31:0]  rsp_rdata;
  logic [59:0]  src_req = '0;
  logic         entry_valid = 1'b0, exit_valid = 1'b0;
  logic [5:0]   entry_id = '0, exit_id = '0;
  logic [59:0]  enable_o, pending_o, active_o;
  logic [239:0] prio_o;

  int n_checks = 0, n_errs = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  logic [59:0] m_en = '0, m_pd = '0, m_act = '0;
  logic [3:0]  m_prio [60];

  always #2.5 clk = ~clk;

  irq_state_bank u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_be(req_be), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata), .src_req(src_req), .entry_valid(entry_valid),
    .entry_id(entry_id), .exit_valid(exit_valid), .exit_id(exit_id),
    .enable_o(enable_o), .pending_o(pending_o), .active_o(active_o),
    .prio_o(prio_o)
  );

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [59:0] word_vec(int w, logic [31:0] d);
    logic [63:0] t = '0;
    t[w*32 +: 32] = d;
    return t[59:0];
  endfunction

  function automatic logic [31:0] vec_word(logic [59:0] v, int w);
    logic [63:0] t = {4'h0, v};
    return t[w*32 +: 32];
  endfunction

  function automatic void model_write(logic [11:0] a, logic [31:0] d, logic [3:0] be);
    logic [31:0] m;
    int w;
    for (int l = 0; l < 4; l++) m[l*8 +: 8] = be[l] ? d[l*8 +: 8] : 8'h00;
    w = a[2];
    if (a == 12'h000 || a == 12'h004) m_en = m_en | word_vec(w, m);
    else if (a == 12'h080 || a == 12'h084) m_en = m_en & ~word_vec(w, m);
    else if (a == 12'h100 || a == 12'h104) m_pd = m_pd | word_vec(w, m);
    else if (a == 12'h180 || a == 12'h184) m_pd = m_pd & ~word_vec(w, m);
    else if (a >= 12'h300 && a < 12'h33C) begin
      for (int l = 0; l < 4; l++) begin
        int s = (int'(a) - 'h300) + l;
        if (be[l] && s < 60) m_prio[s] = m[l*8+4 +: 4];
      end
    end
  endfunction

  function automatic logic [31:0] model_read(logic [11:0] a);
    logic [31:0] r = '0;
    int w = a[2];
    if (a == 12'h000 || a == 12'h004 || a == 12'h080 || a == 12'h084) r = vec_word(m_en, w);
    else if (a == 12'h100 || a == 12'h104 || a == 12'h180 || a == 12'h184) r = vec_word(m_pd, w);
    else if (a == 12'h200 || a == 12'h204) r = vec_word(m_act, w);
    else if (a >= 12'h300 && a < 12'h33C) begin
      for (int l = 0; l < 4; l++) begin
        int s = (int'(a) - 'h300) + l;
        if (s < 60) r[l*8 +: 8] = {m_prio[s], 4'h0};
      end
    end
    return r;
  endfunction

  task automatic bus_write(logic [11:0] a, logic [31:0] d, logic [3:0] be);
    @(posedge clk); #1;
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d; req_be = be;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1;
    req_valid = 0; req_write = 0;
    model_write(a, d, be);
  endtask

  task automatic bus_read(logic [11:0] a, string tag);
    exp_q.push_back(model_read(a));
    tag_q.push_back(tag);
    @(posedge clk); #1;
    req_valid = 1; req_write = 0; req_addr = a;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  task automatic pulse_src(int n);
    @(posedge clk); #1; src_req[n] = 1'b1;
    @(posedge clk); #1; src_req = '0;
    m_pd[n] = 1'b1;
  endtask

  task automatic handler_entry(int n);
    @(posedge clk); #1; entry_valid = 1; entry_id = 6'(n);
    @(posedge clk); #1; entry_valid = 0;
    m_pd[n] = 1'b0; m_act[n] = 1'b1;
  endtask

  task automatic handler_exit(int n);
    @(posedge clk); #1; exit_valid = 1; exit_id = 6'(n);
    @(posedge clk); #1; exit_valid = 0;
    m_act[n] = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
      $finish;
    end
  endtask

  // Scoreboard monitor: pop one expected word per taken response.
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        check("R10 unexpected response", {32'h0, rsp_rdata}, 64'hDEAD);
      end else begin
        check(tag_q.pop_front(), {32'h0, rsp_rdata}, {32'h0, exp_q.pop_front()});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_errs++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] hold;
    for (int i = 0; i < 60; i++) m_prio[i] = 4'h0;
    repeat (3) @(posedge clk); #1;
    rst_n = 1;
    @(negedge clk);
    check("R1 enable reset", enable_o, 0);
    check("R1 pending reset", pending_o, 0);
    check("R1 active reset", active_o, 0);
    check("R1 prio reset", prio_o[63:0], 0);
    check("R1 rsp_valid reset", rsp_valid, 0);
    bus_read(12'h300, "R1 prio read after reset");

    // R2 set-enable
    bus_write(12'h000, 32'h0000_0005, 4'hF);
    bus_read(12'h000, "R2 set-enable readback");
    bus_read(12'h080, "R2 read via clear address");
    bus_write(12'h000, 32'h0, 4'hF);
    bus_read(12'h000, "R2 zero bits no effect");
    // R8 reserved bits of word 1
    bus_write(12'h004, 32'hFFFF_FFFF, 4'hF);
    bus_read(12'h004, "R8 reserved bits read zero");
    @(negedge clk);
    check("R2 enable_o pins", enable_o, m_en);

    // R3 clear-enable
    bus_write(12'h080, 32'h0000_0001, 4'hF);
    bus_read(12'h000, "R3 clear-enable word0");
    bus_write(12'h084, 32'h8000_0001, 4'hF);
    bus_read(12'h004, "R3 clear-enable word1");
    @(negedge clk);
    check("R3 enable_o pins", enable_o, m_en);

    // R4 pending set/clear
    bus_write(12'h100, 32'h0000_0030, 4'hF);
    bus_write(12'h180, 32'h0000_0010, 4'hF);
    bus_read(12'h100, "R4 pending word0");
    bus_write(12'h104, 32'h0800_0000, 4'hF);
    bus_read(12'h184, "R4 pending word1 source 59");

    // R5 hardware request, and collision with clear-pending
    pulse_src(7);
    @(negedge clk);
    check("R5 src pulse sets pending", pending_o, m_pd);
    @(posedge clk); #1;
    req_valid = 1; req_write = 1; req_addr = 12'h180; req_wdata = 32'h0000_0200; req_be = 4'hF;
    src_req[9] = 1'b1;
    @(negedge clk);
    check("R5 ready for collision write", req_ready, 1);
    @(posedge clk); #1;
    req_valid = 0; req_write = 0; src_req = '0;
    m_pd[9] = 1'b1;
    @(negedge clk);
    check("R5 hardware set wins", pending_o[9], 1);

    // R6 handler entry and exit
    handler_entry(5);
    @(negedge clk);
    check("R6 entry clears pending", pending_o[5], 0);
    check("R6 entry sets active", active_o, m_act);
    bus_read(12'h200, "R6 active word0");
    handler_entry(59);
    bus_read(12'h204, "R6 active word1 source 59");
    handler_exit(5);
    @(negedge clk);
    check("R6 exit clears active", active_o, m_act);

    // R7 active words ignore writes
    bus_write(12'h200, 32'hFFFF_FFFF, 4'hF);
    bus_write(12'h204, 32'h0, 4'hF);
    @(negedge clk);
    check("R7 active unchanged", active_o, m_act);
    bus_read(12'h204, "R7 active readback");

    // R9 priority bytes with lane strobes
    bus_write(12'h300, 32'hABCD_EF12, 4'b0101);
    bus_read(12'h300, "R9 priority lanes and low nibble");
    bus_write(12'h338, 32'hFFFF_FFFF, 4'hF);
    bus_read(12'h338, "R9 last priority word");
    @(negedge clk);
    check("R9 prio_o source 59", prio_o[59*4 +: 4], 4'hF);
    check("R9 prio_o source 2", prio_o[2*4 +: 4], 4'hC);

    // R11 unmapped space
    bus_write(12'h33C, 32'hFFFF_FFFF, 4'hF);
    bus_read(12'h33C, "R11 past priority array");
    bus_write(12'h400, 32'hFFFF_FFFF, 4'hF);
    bus_read(12'h400, "R11 unmapped read");
    @(negedge clk);
    check("R11 enable untouched", enable_o, m_en);

    // R10 back-pressure on the response
    @(posedge clk); #1;
    rsp_ready = 0;
    exp_q.push_back(model_read(12'h000)); tag_q.push_back("R10 first held response");
    req_valid = 1; req_write = 0; req_addr = 12'h000;
    @(negedge clk);
    @(posedge clk); #1;
    exp_q.push_back(model_read(12'h100)); tag_q.push_back("R10 second response");
    req_addr = 12'h100;
    @(negedge clk);
    check("R10 rsp_valid after read", rsp_valid, 1);
    check("R10 req_ready low while stalled", req_ready, 0);
    hold = rsp_rdata;
    @(negedge clk);
    check("R10 data held", {rsp_valid, rsp_rdata}, {1'b1, hold});
    @(posedge clk); #1;
    rsp_ready = 1;
    @(negedge clk);
    @(posedge clk); #1;
    req_valid = 0;
    repeat (4) @(negedge clk);
    check("R10 all responses seen", exp_q.size(), 0);

    finish_run();
  end
endmodule